// File: doc/BRIEF.md
# Byte-to-Pixel Panel Bus Assembler

This block takes a continuous 8-bit byte stream, one byte per clock, along with the active-low line and frame syncs that frame it. It packs consecutive bytes into whole pixels for a parallel TFT panel input. Two packings can be selected. In the 16-bit 5-6-5 packing, two bytes make one pixel. In the 24-bit 8-8-8 packing, three bytes make one pixel. Bytes arrive most significant first.

Each completed pixel leaves the block on a 24-bit pixel bus together with a one-cycle pixel clock enable. The two syncs pass through a delay line whose length equals the pixel path latency for the active packing. The panel therefore sees syncs and pixel data in the same relative timing that the byte source produced.

A falling edge on either sync realigns the byte phase, so the byte that arrives with that edge always starts a new pixel. The packing select is sampled only in the cycle where the frame sync falls.

Top module: `pixbus_asm`

## Requirements
- R1: While reset is asserted, `pix_o` is zero, `pix_ce_o` is low, and both `hsync_no` and `vsync_no` are high.
- R2: In 5-6-5 mode (active select value 0), a pixel is built from two bytes b0 then b1. It appears as `pix_o[23:16]`=0, `pix_o[15:8]`=b0, `pix_o[7:0]`=b1.
- R3: In 8-8-8 mode (active select value 1), a pixel is built from three bytes b0, b1, b2 in arrival order. It appears as `pix_o[23:16]`=b0, `pix_o[15:8]`=b1, `pix_o[7:0]`=b2.
- R4: In 5-6-5 mode, `pix_ce_o` is high for exactly one cycle, 3 cycles after the cycle that presented b0. `pix_o` carries the pixel in that cycle.
- R5: In 8-8-8 mode, `pix_ce_o` is high for exactly one cycle, 5 cycles after the cycle that presented b0. `pix_o` carries the pixel in that cycle.
- R6: `hsync_no` and `vsync_no` repeat `hsync_ni` and `vsync_ni` delayed by the active mode's latency: 3 cycles in 5-6-5 mode and 5 cycles in 8-8-8 mode.
- R7: A falling edge on `hsync_ni` or `vsync_ni` makes the byte in that same cycle b0 of a new pixel. Bytes of an unfinished pixel before the edge produce no strobe.
- R8: `fmt_sel_i` is sampled only in a cycle where `vsync_ni` falls (high in the previous cycle, low now). The new mode governs the byte of that cycle. At all other times the select has no effect.
- R9: Between strobes, `pix_o` keeps the value of the most recent pixel.
- R10: While the mode stays the same, `pix_ce_o` is never high in two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Byte clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| byte_i | input | 8 | Incoming byte, one per clock |
| hsync_ni | input | 1 | Line sync, active low |
| vsync_ni | input | 1 | Frame sync, active low |
| fmt_sel_i | input | 1 | Packing select: 0 for 5-6-5, 1 for 8-8-8 |
| pix_o | output | 24 | Assembled pixel |
| pix_ce_o | output | 1 | One-cycle pixel clock enable |
| hsync_no | output | 1 | Delayed line sync |
| vsync_no | output | 1 | Delayed frame sync |

## Verification
The bench uses lines whose lengths are not multiples of the pixel size. If the byte phase were not realigned at each sync edge, every pixel would come out byte-shifted; if leftover bytes were not discarded, a pixel built from a stale fragment would appear.

Very short lines and frame syncs that fall without a line sync test the realignment path on its own. This catches a design that realigns only on the line sync.

The select toggles randomly on every cycle. A design that sampled it outside the frame sync edge would switch packing and latency mid-frame. In that case the sync delay would drift from the pixel delay and the pixel fields would land in the wrong bytes. Both of these show up as miscompares on the pixel bus and on the delayed syncs.

// File: rtl/pba_pkg.sv
package pba_pkg;

   typedef enum logic {
      FMT_565 = 1'b0,
      FMT_888 = 1'b1
   } pix_fmt_e;

   // Phase index of the final byte of a pixel
   function automatic logic [1:0] final_phase(input pix_fmt_e f);
      return (f == FMT_888) ? 2'd2 : 2'd1;
   endfunction

   // Number of bytes per pixel
   function automatic int unsigned bytes_per_pix(input pix_fmt_e f);
      return (f == FMT_888) ? 3 : 2;
   endfunction

endpackage

// File: rtl/pba_frame_ctl.sv
module pba_frame_ctl
   import pba_pkg::*;
(
   input  logic       clk_i,
   input  logic       rst_ni,
   input  logic       hsync_ni,
   input  logic       vsync_ni,
   input  logic       fmt_sel_i,
   output logic [1:0] cur_phase_o,
   output logic       last_byte_o,
   output pix_fmt_e   fmt_eff_o,
   output pix_fmt_e   fmt_act_o
);

   logic     hs_q, vs_q;
   logic     line_start, frame_start;
   logic [1:0] phase_q;
   pix_fmt_e fmt_q;

   assign frame_start = vs_q & ~vsync_ni;
   assign line_start  = (hs_q & ~hsync_ni) | frame_start;

   always_comb begin
      fmt_eff_o   = frame_start ? pix_fmt_e'(fmt_sel_i) : fmt_q;
      cur_phase_o = line_start ? 2'd0 : phase_q;
      last_byte_o = (cur_phase_o == final_phase(fmt_eff_o));
   end

   assign fmt_act_o = fmt_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         hs_q    <= 1'b1;
         vs_q    <= 1'b1;
         phase_q <= 2'd0;
         fmt_q   <= FMT_565;
      end else begin
         hs_q    <= hsync_ni;
         vs_q    <= vsync_ni;
         phase_q <= last_byte_o ? 2'd0 : cur_phase_o + 2'd1;
         if (frame_start) fmt_q <= pix_fmt_e'(fmt_sel_i);
      end
   end

endmodule

// File: rtl/pba_pack.sv
module pba_pack
   import pba_pkg::*;
#(
   parameter int unsigned BYTE_W = 8,
   localparam int unsigned PIX_W = 3 * BYTE_W
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic [BYTE_W-1:0] byte_i,
   input  logic [1:0]        cur_phase_i,
   input  logic              last_byte_i,
   input  pix_fmt_e          fmt_eff_i,
   output logic [PIX_W-1:0]  pix_o,
   output logic              pix_vld_o
);

   logic [2*BYTE_W-1:0] acc_q;
   logic [PIX_W-1:0]    word_565, word_888, word_sel;

   assign word_565 = {{BYTE_W{1'b0}}, acc_q[BYTE_W-1:0], byte_i};
   assign word_888 = {acc_q, byte_i};
   assign word_sel = (fmt_eff_i == FMT_888) ? word_888 : word_565;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         acc_q     <= '0;
         pix_o     <= '0;
         pix_vld_o <= 1'b0;
      end else begin
         if (cur_phase_i == 2'd0) acc_q <= {{BYTE_W{1'b0}}, byte_i};
         else                     acc_q <= {acc_q[BYTE_W-1:0], byte_i};
         pix_vld_o <= last_byte_i;
         if (last_byte_i) pix_o <= word_sel;
      end
   end

endmodule

// File: rtl/pba_tap_delay.sv
module pba_tap_delay #(
   parameter int unsigned W = 1,
   parameter int unsigned DEPTH = 2,
   parameter logic [W-1:0] RST_VAL = '0,
   localparam int unsigned TAP_W = $clog2(DEPTH + 1)
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic [W-1:0]     d_i,
   input  logic [TAP_W-1:0] tap_i,
   output logic [W-1:0]     q_o
);

   logic [DEPTH-1:0][W-1:0] stg_q;

   if (DEPTH < 1) begin : g_depth_chk
      $error("pba_tap_delay: DEPTH must be at least 1");
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         stg_q <= {DEPTH{RST_VAL}};
      end else begin
         for (int s = DEPTH - 1; s > 0; s--) stg_q[s] <= stg_q[s-1];
         stg_q[0] <= d_i;
      end
   end

   // tap_i selects how many register stages the data passes; 0 bypasses
   always_comb begin
      q_o = d_i;
      for (int s = 0; s < DEPTH; s++) begin
         if (tap_i == TAP_W'(s + 1)) q_o = stg_q[s];
      end
   end

endmodule

// File: rtl/pixbus_asm.sv
module pixbus_asm
   import pba_pkg::*;
#(
   parameter int unsigned BYTE_W  = 8,
   parameter int unsigned LAT_565 = 3,
   parameter int unsigned LAT_888 = 5
) (
   input  logic                  clk_i,
   input  logic                  rst_ni,
   input  logic [BYTE_W-1:0]     byte_i,
   input  logic                  hsync_ni,
   input  logic                  vsync_ni,
   input  logic                  fmt_sel_i,
   output logic [3*BYTE_W-1:0]   pix_o,
   output logic                  pix_ce_o,
   output logic                  hsync_no,
   output logic                  vsync_no
);

   localparam int unsigned PIX_W   = 3 * BYTE_W;
   localparam int unsigned SYNC_D  = (LAT_888 > LAT_565) ? LAT_888 : LAT_565;
   localparam int unsigned PAD_565 = LAT_565 - 2;
   localparam int unsigned PAD_888 = LAT_888 - 3;
   localparam int unsigned PIX_D   = (PAD_888 > PAD_565) ? PAD_888 : PAD_565;
   localparam int unsigned STAP_W  = $clog2(SYNC_D + 1);
   localparam int unsigned PTAP_W  = $clog2(PIX_D + 1);
   localparam int unsigned N_SYNC  = 2;

   if (BYTE_W < 1) begin : g_bw_chk
      $error("pixbus_asm: BYTE_W must be positive");
   end
   if (LAT_565 < 3) begin : g_l565_chk
      $error("pixbus_asm: LAT_565 must be at least 3");
   end
   if (LAT_888 < 4) begin : g_l888_chk
      $error("pixbus_asm: LAT_888 must be at least 4");
   end

   logic [1:0]        cur_phase;
   logic              last_byte;
   pix_fmt_e          fmt_eff, fmt_act;
   logic [PIX_W-1:0]  pix_q;
   logic              pix_vld;
   logic [STAP_W-1:0] sync_tap;
   logic [PTAP_W-1:0] pix_tap;
   logic [N_SYNC-1:0] sync_in, sync_out;

   pba_frame_ctl u_ctl (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .hsync_ni    (hsync_ni),
      .vsync_ni    (vsync_ni),
      .fmt_sel_i   (fmt_sel_i),
      .cur_phase_o (cur_phase),
      .last_byte_o (last_byte),
      .fmt_eff_o   (fmt_eff),
      .fmt_act_o   (fmt_act)
   );

   pba_pack #(.BYTE_W(BYTE_W)) u_pack (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .byte_i      (byte_i),
      .cur_phase_i (cur_phase),
      .last_byte_i (last_byte),
      .fmt_eff_i   (fmt_eff),
      .pix_o       (pix_q),
      .pix_vld_o   (pix_vld)
   );

   assign sync_tap = (fmt_act == FMT_888) ? STAP_W'(LAT_888) : STAP_W'(LAT_565);
   assign pix_tap  = (fmt_act == FMT_888) ? PTAP_W'(PAD_888) : PTAP_W'(PAD_565);

   assign sync_in  = {vsync_ni, hsync_ni};

   for (genvar c = 0; c < N_SYNC; c++) begin : g_sync
      pba_tap_delay #(.W(1), .DEPTH(SYNC_D), .RST_VAL(1'b1)) u_dly (
         .clk_i  (clk_i),
         .rst_ni (rst_ni),
         .d_i    (sync_in[c]),
         .tap_i  (sync_tap),
         .q_o    (sync_out[c])
      );
   end

   assign hsync_no = sync_out[0];
   assign vsync_no = sync_out[1];

   pba_tap_delay #(.W(PIX_W + 1), .DEPTH(PIX_D), .RST_VAL('0)) u_pix_dly (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .d_i    ({pix_vld, pix_q}),
      .tap_i  (pix_tap),
      .q_o    ({pix_ce_o, pix_o})
   );

endmodule

// File: rtl/pixbus_asm_chk.sv
module pixbus_asm_chk #(
   parameter int unsigned BYTE_W  = 8,
   parameter int unsigned LAT_565 = 3,
   parameter int unsigned LAT_888 = 5,
   localparam int unsigned PIX_W  = 3 * BYTE_W
) (
   input logic             clk_i,
   input logic             rst_ni,
   input logic             hsync_ni,
   input logic             vsync_ni,
   input logic             hsync_no,
   input logic [PIX_W-1:0] pix_o,
   input logic             pix_ce_o,
   input logic             fmt_act
);

   localparam int unsigned HIST = 8;

   if (LAT_565 > HIST || LAT_888 > HIST) begin : g_hist_chk
      $error("pixbus_asm_chk: latency exceeds history depth");
   end

   logic [HIST-1:0] hs_hist;
   logic            vs_q, ce_q, fmt_q;
   logic [3:0]      settle_cnt;
   logic            settled, frame_fall;
   int unsigned     lat_now;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         hs_hist    <= '1;
         vs_q       <= 1'b1;
         ce_q       <= 1'b0;
         fmt_q      <= 1'b0;
         settle_cnt <= '0;
      end else begin
         hs_hist    <= {hs_hist[HIST-2:0], hsync_ni};
         vs_q       <= vsync_ni;
         ce_q       <= pix_ce_o;
         fmt_q      <= fmt_act;
         if (fmt_act != fmt_q)      settle_cnt <= '0;
         else if (settle_cnt != 4'hF) settle_cnt <= settle_cnt + 4'd1;
      end
   end

   assign settled    = (settle_cnt >= 4'd8) && (fmt_act == fmt_q);
   assign frame_fall = vs_q & ~vsync_ni;
   assign lat_now    = fmt_act ? LAT_888 : LAT_565;

   // R8
   fmt_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !frame_fall |=> $stable(fmt_act));

   // R6
   hs_delay_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      settled |-> (hsync_no == hs_hist[lat_now-1]));

   // R9
   pix_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (settled && !pix_ce_o) |-> $stable(pix_o));

   // R10
   no_b2b_strobe_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (settled && pix_ce_o) |-> !ce_q);

   // R2
   upper_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (settled && pix_ce_o && !fmt_act) |-> (pix_o[PIX_W-1:2*BYTE_W] == '0));

endmodule

bind pixbus_asm pixbus_asm_chk #(
   .BYTE_W  (BYTE_W),
   .LAT_565 (LAT_565),
   .LAT_888 (LAT_888)
) u_chk (
   .clk_i    (clk_i),
   .rst_ni   (rst_ni),
   .hsync_ni (hsync_ni),
   .vsync_ni (vsync_ni),
   .hsync_no (hsync_no),
   .pix_o    (pix_o),
   .pix_ce_o (pix_ce_o),
   .fmt_act  (fmt_act)
);

// File: tb/pixbus_asm_tb_top.sv
`timescale 1ns/1ps
module pixbus_asm_tb_top;

   localparam int L565 = 3;
   localparam int L888 = 5;
   localparam int NCYC = 6000;

   logic        clk_i = 1'b0;
   logic        rst_ni;
   logic [7:0]  byte_i;
   logic        hsync_ni, vsync_ni, fmt_sel_i;
   logic [23:0] pix_o;
   logic        pix_ce_o, hsync_no, vsync_no;

   always #4 clk_i = ~clk_i;

   pixbus_asm dut_i (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .byte_i    (byte_i),
      .hsync_ni  (hsync_ni),
      .vsync_ni  (vsync_ni),
      .fmt_sel_i (fmt_sel_i),
      .pix_o     (pix_o),
      .pix_ce_o  (pix_ce_o),
      .hsync_no  (hsync_no),
      .vsync_no  (vsync_no)
   );

   int    n_vec = 0;
   int    n_bad = 0;
   int    cyc = 0;
   string seg = "reset";
   bit    done = 0;

   bit          hs_a [NCYC];
   bit          vs_a [NCYC];
   bit          fm_a [NCYC];
   bit          pv_a [NCYC+1];
   logic [23:0] px_a [NCYC+1];

   bit         m_hs = 1, m_vs = 1, m_fmt = 0;
   int         m_ph = 0;
   logic [7:0] m_b0 = 0, m_b1 = 0;
   bit         prev_ce = 0;

   task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
      n_vec++;
      if (got !== exp) begin
         n_bad++;
         $display("FAIL %s (%s) cycle %0d: got %h expected %h", req, seg, cyc, got, exp);
      end
   endtask

   function automatic bit hist_sync(input bit is_v, input int idx);
      if (idx < 0) return 1'b1;
      return is_v ? vs_a[idx] : hs_a[idx];
   endfunction

   function automatic bit fmt_steady(input int k);
      if (k < 8) return 1'b0;
      for (int j = k - 8; j < k; j++) if (fm_a[j] != fm_a[k]) return 1'b0;
      return 1'b1;
   endfunction

   // One byte clock: drive, update the model, check at the falling edge
   task automatic step(input bit hs, input bit vs, input bit sel, input logic [7:0] b);
      bit   lstart, fstart, fe, last;
      int   ph, lat, pad;
      logic [23:0] word;
      if (cyc >= NCYC - 1) return;
      hsync_ni = hs; vsync_ni = vs; fmt_sel_i = sel; byte_i = b;
      hs_a[cyc] = hs; vs_a[cyc] = vs; fm_a[cyc] = m_fmt;
      fstart = m_vs && !vs;
      lstart = (m_hs && !hs) || fstart;
      fe     = fstart ? sel : m_fmt;
      ph     = lstart ? 0 : m_ph;
      last   = (ph == (fe ? 2 : 1));
      word   = fe ? {m_b0, m_b1, b} : {8'h00, m_b0, b};
      if (last) begin
         px_a[cyc+1] = word; pv_a[cyc+1] = 1'b1;
      end else begin
         px_a[cyc+1] = px_a[cyc]; pv_a[cyc+1] = 1'b0;
      end
      if (ph == 0) m_b0 = b;
      if (ph == 1) m_b1 = b;
      m_ph = last ? 0 : ph + 1;
      if (fstart) m_fmt = sel;
      m_hs = hs; m_vs = vs;

      @(negedge clk_i);
      lat = fm_a[cyc] ? L888 : L565;
      pad = fm_a[cyc] ? L888 - 3 : L565 - 2;
      chk("R6", {31'd0, hsync_no}, {31'd0, hist_sync(1'b0, cyc - lat)});
      chk("R6", {31'd0, vsync_no}, {31'd0, hist_sync(1'b1, cyc - lat)});
      chk(fm_a[cyc] ? "R5/R7/R8" : "R4/R7/R8", {31'd0, pix_ce_o}, {31'd0, pv_a[cyc-pad]});
      if (pv_a[cyc-pad]) chk(fm_a[cyc] ? "R3" : "R2", {8'd0, pix_o}, {8'd0, px_a[cyc-pad]});
      else               chk("R9", {8'd0, pix_o}, {8'd0, px_a[cyc-pad]});
      if (fmt_steady(cyc)) chk("R10", {31'd0, pix_ce_o & prev_ce}, 32'd0);
      prev_ce = pix_ce_o;
      cyc++;
      @(posedge clk_i); #1;
   endtask

   task automatic line(input int len, input bit frame, input int hs_w, input int sel_mode);
      for (int i = 0; i < hs_w; i++)
         step(1'b0, !(frame && i < 2), sel_mode < 0 ? 1'($urandom) : 1'(sel_mode), 8'($urandom));
      for (int i = 0; i < len; i++)
         step(1'b1, 1'b1, 1'($urandom), 8'($urandom));
   endtask

   initial begin
      void'($urandom(32'h5EED_0123));
      rst_ni = 1'b0; hsync_ni = 1'b1; vsync_ni = 1'b1; fmt_sel_i = 1'b0; byte_i = 8'h00;
      px_a[0] = '0; pv_a[0] = 1'b0;
      repeat (3) begin
         @(negedge clk_i);
         chk("R1", {8'd0, pix_o}, 32'd0);
         chk("R1", {31'd0, pix_ce_o}, 32'd0);
         chk("R1", {31'd0, hsync_no}, 32'd1);
         chk("R1", {31'd0, vsync_no}, 32'd1);
      end
      @(posedge clk_i); #1;
      rst_ni = 1'b1;

      seg = "R2/R3 random frames";
      for (int f = 0; f < 8; f++)
         for (int l = 0; l < 6; l++)
            line(20 + int'($urandom % 21), l == 0, 2, -1);

      seg = "R7 short lines";
      for (int l = 0; l < 40; l++)
         line(1 + int'($urandom % 5), (l % 10) == 0, 1, -1);

      seg = "R7/R8 frame sync without line sync";
      for (int p = 0; p < 12; p++) begin
         step(1'b1, 1'b0, 1'($urandom), 8'($urandom));
         for (int i = 0; i < 3 + int'($urandom % 6); i++)
            step(1'b1, 1'b1, 1'($urandom), 8'($urandom));
      end

      seg = "R10 steady 8-8-8 then 5-6-5";
      line(60, 1'b1, 2, 1);
      for (int l = 0; l < 4; l++) line(45, 1'b0, 2, -1);
      line(60, 1'b1, 2, 0);
      for (int l = 0; l < 4; l++) line(45, 1'b0, 2, -1);

      seg = "R8 select toggles mid-frame";
      for (int f = 0; f < 4; f++)
         for (int l = 0; l < 5; l++)
            line(25 + int'($urandom % 10), l == 0, 3, -1);

      seg = "drain";
      for (int i = 0; i < 10; i++) step(1'b1, 1'b1, 1'b0, 8'h00);

      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk_i);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog (all requirements): got timeout expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   end

endmodule